// File: doc/BRIEF.md
# Encoder Input Deglitcher

This block sits between the three raw pins of an incremental position encoder (two quadrature phases and an index mark) and the decoder that counts them. Every pin first crosses into the block clock through a chain of synchronising flops. After that chain, a per-pin counter filter removes short noise pulses. A pin's new level reaches the output only when it has held still for longer than a programmable window. All three pins share one length value and one enable bit.

The window is the programmed length plus two clock periods. A length of zero therefore gives a two-cycle window, and a one-cycle window cannot be set. A pulse as long as the window, or shorter, never reaches the output. With the filter turned off, the output is simply the synchronised pin.

The length and the enable bit are copied into shadow registers while the lock input is low. While the lock input is high the shadow registers hold their values, so the configuration cannot move under a running decoder.

Top module: `glitch_guard`

## Requirements
- R1: While reset is asserted and on the first cycles after it is released, every bit of `clean_o` is 0.
- R2: With the shadowed enable at 0, each `clean_o` bit follows its `raw_i` bit with exactly two clock edges of latency, and a pulse lasting a single clock period still appears on the output.
- R3: With filtering on and window W = length + 2, a level change on `raw_i` that first becomes visible at clock edge e0 has not yet reached `clean_o` after edge e(W+1).
- R4: With filtering on, a pulse that holds for exactly W clock edges never changes `clean_o`.
- R5: With filtering on, a level that holds for W+1 or more edges reaches `clean_o` just after edge e(W+2), which is W+3 edges after it first becomes visible.
- R6: Filtering is symmetric: a low-going pulse of W edges on a high output is rejected, and a longer low level is passed.
- R7: A channel's counter restarts whenever its synchronised input returns to the output level. Two pulses of W edges separated by a one-cycle gap are both rejected.
- R8: Channels are filtered independently. A glitch on one pin neither delays nor alters the acceptance of a stable level on another pin, and a quiet pin stays at 0.
- R9: While `cfg_lock` is 1, changes on `flt_en_i` and `flt_len_i` have no effect. The configuration captured before the lock keeps governing the outputs, and a new value takes effect once the lock is released.
- R10: A length of 0 gives a two-edge window: a pulse of 2 edges is rejected, and 3 edges are passed with a latency of 5 edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_lock | input | 1 | 1 holds the shadowed length and enable; 0 lets them load every cycle |
| flt_en_i | input | 1 | Filter enable request (1 = filter, 0 = synchroniser only) |
| flt_len_i | input | LEN_W (21) | Programmed length; window = value + 2 clock periods |
| raw_i | input | NCH (3) | Asynchronous encoder pins: bit 0 phase A, bit 1 phase B, bit 2 index |
| clean_o | output | NCH (3) | Synchronised, deglitched levels |

## Verification
Pulses of exactly the window length and of one edge more are applied at two lengths (5 and 0). These show whether the plus-two offset and the strict "longer than" comparison are right, and they also check the acceptance latency on both rising and falling levels. A pulse-gap-pulse train shows whether the counter restarts or accumulates. A glitch on one pin during a stable level on another shows whether the channels stay independent. Single-cycle pulses in bypass, and a locked configuration change followed by a pulse that only the new setting would pass, show the synchroniser path and the shadow hold.

// File: rtl/glitch_guard_pkg.sv
package glitch_guard_pkg;
   // Fixed distance between the programmed length and the filter window.
   localparam int unsigned GG_WIN_OFFSET = 2;

   // The counter must reach length + offset, so it needs one extra bit.
   function automatic int unsigned gg_cnt_width(input int unsigned len_w);
      return len_w + 1;
   endfunction
endpackage

// File: rtl/glitch_guard_sync.sv
module glitch_guard_sync #(
   parameter int unsigned WIDTH  = 3,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("glitch_guard_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stg_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
      end else begin
         stg_q[0] <= d_i;
         for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
      end
   end

   assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/glitch_guard_cfg.sv
module glitch_guard_cfg
   import glitch_guard_pkg::*;
#(
   parameter int unsigned LEN_W = 21,
   localparam int unsigned CNT_W = gg_cnt_width(LEN_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lock_i,
   input  logic             en_i,
   input  logic [LEN_W-1:0] len_i,
   output logic             en_o,
   output logic [CNT_W-1:0] win_o
);
   logic             en_q;
   logic [LEN_W-1:0] len_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         len_q <= '0;
      end else if (!lock_i) begin
         en_q  <= en_i;
         len_q <= len_i;
      end
   end

   assign en_o  = en_q;
   assign win_o = CNT_W'({1'b0, len_q}) + CNT_W'(GG_WIN_OFFSET);

   // Locked configuration must not move.
   p_lock_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      lock_i |=> ($stable(len_q) && $stable(en_q)));
endmodule

// File: rtl/glitch_guard_chan.sv
module glitch_guard_chan #(
   parameter int unsigned CNT_W = 22
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic [CNT_W-1:0] win_i,
   input  logic             s_i,
   output logic             filt_o
);
   logic             filt_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         filt_q <= 1'b0;
         cnt_q  <= '0;
      end else if (!en_i) begin
         filt_q <= s_i;            // track so enabling causes no step
         cnt_q  <= '0;
      end else if (s_i == filt_q) begin
         cnt_q  <= '0;
      end else if (cnt_q >= win_i) begin
         filt_q <= s_i;            // held for window + 1 edges
         cnt_q  <= '0;
      end else begin
         cnt_q  <= cnt_q + 1'b1;
      end
   end

   assign filt_o = filt_q;

   p_track_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> (filt_q == $past(s_i)));

   p_full_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(en_i) && (filt_q != $past(filt_q))) |-> ($past(cnt_q) >= $past(win_i)));

   p_new_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (filt_q != $past(filt_q)) |-> (filt_q == $past(s_i)));

   p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && (s_i == filt_q)) |=> (cnt_q == '0));
endmodule

// File: rtl/glitch_guard.sv
module glitch_guard
   import glitch_guard_pkg::*;
#(
   parameter int unsigned NCH         = 3,
   parameter int unsigned LEN_W       = 21,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_lock,
   input  logic             flt_en_i,
   input  logic [LEN_W-1:0] flt_len_i,
   input  logic [NCH-1:0]   raw_i,
   output logic [NCH-1:0]   clean_o
);
   localparam int unsigned CNT_W = gg_cnt_width(LEN_W);

   if (NCH < 1) begin : g_bad_nch
      $error("glitch_guard: NCH must be at least 1");
   end
   if (LEN_W < 1 || LEN_W > 30) begin : g_bad_len
      $error("glitch_guard: LEN_W must lie in 1..30");
   end

   logic             en_w;
   logic [CNT_W-1:0] win_w;
   logic [NCH-1:0]   sync_w;
   logic [NCH-1:0]   filt_w;

   glitch_guard_cfg #(.LEN_W(LEN_W)) u_cfg (
      .clk    (clk),
      .rst_n  (rst_n),
      .lock_i (cfg_lock),
      .en_i   (flt_en_i),
      .len_i  (flt_len_i),
      .en_o   (en_w),
      .win_o  (win_w)
   );

   glitch_guard_sync #(.WIDTH(NCH), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (raw_i),
      .q_o   (sync_w)
   );

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      glitch_guard_chan #(.CNT_W(CNT_W)) u_chan (
         .clk    (clk),
         .rst_n  (rst_n),
         .en_i   (en_w),
         .win_i  (win_w),
         .s_i    (sync_w[c]),
         .filt_o (filt_w[c])
      );
      assign clean_o[c] = en_w ? filt_w[c] : sync_w[c];
   end

   always_comb begin
      if (!rst_n) begin
         p_reset_low_r1: assert (clean_o == '0);
      end
   end
endmodule

// File: tb/glitch_guard_bench.sv
module glitch_guard_bench;
   localparam int unsigned NCH   = 3;
   localparam int unsigned LEN_W = 21;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cfg_lock = 1'b0;
   logic             flt_en_i = 1'b0;
   logic [LEN_W-1:0] flt_len_i = '0;
   logic [NCH-1:0]   raw_i = '0;
   logic [NCH-1:0]   clean_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   glitch_guard #(.NCH(NCH), .LEN_W(LEN_W), .SYNC_STAGES(2)) u_glitch_guard (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_lock  (cfg_lock),
      .flt_en_i  (flt_en_i),
      .flt_len_i (flt_len_i),
      .raw_i     (raw_i),
      .clean_o   (clean_o)
   );

   task automatic check(input string req, input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: clean_o=%b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   // Checks clean_o stays at exp on every negedge for a number of cycles.
   task automatic hold_check(input string req, input int cycles, input logic [NCH-1:0] exp);
      logic [NCH-1:0] seen = exp;
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         if (clean_o !== exp && seen === exp) seen = clean_o;
      end
      check(req, seen, exp);
   endtask

   task automatic configure(input logic en, input int len);
      @(negedge clk);
      cfg_lock  = 1'b0;
      flt_en_i  = en;
      flt_len_i = LEN_W'(len);
      repeat (3) @(negedge clk);
   endtask

   // Drive one channel to lvl for width clock edges, then back.
   task automatic pulse(input int ch, input logic lvl, input int width);
      @(negedge clk);
      raw_i[ch] = lvl;
      repeat (width) @(negedge clk);
      raw_i[ch] = ~lvl;
   endtask

   task automatic t_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 during reset", clean_o, '0);
      rst_n = 1'b1;
      hold_check("R1 after release", 4, '0);
   endtask

   task automatic t_bypass();
      configure(1'b0, 0);
      @(negedge clk);
      raw_i = 3'b101;
      @(posedge clk); @(negedge clk);
      check("R2 one edge", clean_o, 3'b000);
      @(posedge clk); @(negedge clk);
      check("R2 two edges", clean_o, 3'b101);
      raw_i = 3'b111;
      @(negedge clk);
      raw_i = 3'b101;
      @(posedge clk); @(negedge clk);
      check("R2 short pulse seen", clean_o, 3'b111);
      @(posedge clk); @(negedge clk);
      check("R2 short pulse ends", clean_o, 3'b101);
      raw_i = '0;
      repeat (4) @(negedge clk);
   endtask

   task automatic t_window(input int len, input string tag);
      int w = len + 2;
      configure(1'b1, len);
      pulse(0, 1'b1, w);
      hold_check({tag, " R4 pulse of window rejected"}, w + 6, 3'b000);
      @(negedge clk);
      raw_i[0] = 1'b1;
      repeat (w + 2) @(posedge clk);
      @(negedge clk);
      check({tag, " R3 not before latency"}, clean_o, 3'b000);
      @(posedge clk); @(negedge clk);
      check({tag, " R5 accepted at latency"}, clean_o, 3'b001);
      pulse(0, 1'b0, w);
      hold_check({tag, " R6 low pulse rejected"}, w + 6, 3'b001);
      @(negedge clk);
      raw_i[0] = 1'b0;
      repeat (w + 2) @(posedge clk);
      @(negedge clk);
      check({tag, " R6 fall not early"}, clean_o, 3'b001);
      @(posedge clk); @(negedge clk);
      check({tag, " R6 fall accepted"}, clean_o, 3'b000);
   endtask

   task automatic t_restart();
      int w = 5;
      configure(1'b1, 3);
      @(negedge clk);
      raw_i[1] = 1'b1;
      repeat (w) @(negedge clk);
      raw_i[1] = 1'b0;
      @(negedge clk);
      raw_i[1] = 1'b1;
      repeat (w) @(negedge clk);
      raw_i[1] = 1'b0;
      hold_check("R7 split pulses rejected", w + 6, 3'b000);
   endtask

   task automatic t_independent();
      int w = 5;
      configure(1'b1, 3);
      @(negedge clk);
      raw_i = 3'b011;
      repeat (w) @(negedge clk);
      raw_i[0] = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      check("R8 stable pin not early", clean_o, 3'b000);
      @(posedge clk); @(negedge clk);
      check("R8 stable pin accepted on time", clean_o, 3'b010);
      hold_check("R8 glitch pin and quiet pin stay low", 10, 3'b010);
      raw_i = '0;
      repeat (w + 6) @(negedge clk);
      check("R8 settle low", clean_o, 3'b000);
   endtask

   task automatic t_lock();
      configure(1'b1, 3);
      @(negedge clk);
      cfg_lock = 1'b1;
      @(negedge clk);
      flt_en_i  = 1'b0;
      flt_len_i = '0;
      repeat (3) @(negedge clk);
      pulse(2, 1'b1, 3);
      hold_check("R9 locked setting still filters", 10, 3'b000);
      cfg_lock = 1'b0;
      repeat (3) @(negedge clk);
      raw_i[2] = 1'b1;
      @(negedge clk);
      raw_i[2] = 1'b0;
      @(posedge clk); @(negedge clk);
      check("R9 released setting bypasses", clean_o, 3'b100);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      t_reset();
      t_bypass();
      t_window(5, "len5");
      t_window(0, "R10 len0");
      t_restart();
      t_independent();
      t_lock();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #1ms;
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: run did not finish, actual hung expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule